// File: doc/BRIEF.md
# Phase-Aligned Sample Demultiplexer

This block accepts one sample on every rising edge of the sample clock and spreads the stream over two output ports, a primary and an auxiliary port. There are three operating modes. In the undivided mode every sample goes straight to the primary port. In the half-rate mode samples are paired. In the quarter-rate mode samples are grouped in fours. A data-ready strobe marks each port update and runs at the divided rate.

A divide counter decides which slot of a group each incoming sample fills. Left alone, that counter could settle into any phase. A synchronous alignment reset input therefore clears it to slot zero. Several of these blocks fed by one reset will then group their samples identically, which is what an interleaved arrangement needs.

The alignment reset also travels through a delay line as deep as the data path. The delayed copy leaves the block as a reset output that lines up with the port data. The sample present at the first edge after release is both the first sample of the first new group and the sample that meets the falling edge of the reset output.

Top module: `sample_demux_aligned`

## Requirements
- R1: Mode is chosen by two static inputs. `demux_en`=0 selects the undivided mode (group of 1). `demux_en`=1 with `div_sel`=0 selects the half-rate mode (group of 2). `demux_en`=1 with `div_sel`=1 selects the quarter-rate mode (group of 4). In the undivided mode, `pri_out[7:0]` carries each sample, `pri_out[15:8]` is zero and `aux_out` is zero.
- R2: Let the last sample of a group be sampled at clock edge k. The ports show that group from edge k+LAT-1 onward, where LAT defaults to 3.
- R3: In the half-rate mode, `aux_out[7:0]` holds the older sample of the pair and `pri_out[7:0]` holds the newer one. The upper bytes of both ports are zero. Both ports update on the same edge.
- R4: In the quarter-rate mode, the four samples s0 (oldest) to s3 are placed as follows: `aux_out` = {s1,s0} and `pri_out` = {s3,s2}, with the older sample of each pair in the low byte.
- R5: `dready` goes high on the edge that updates the ports. In the half-rate mode it stays high 1 cycle and then low 1 cycle. In the quarter-rate mode it stays high 2 cycles and then low 2 cycles. In the undivided mode it is high on every cycle that carries a new sample.
- R6: Outside the undivided mode, `pri_out` and `aux_out` change only in a cycle where `dready` has just risen.
- R7: A sample taken at an edge where `rst_in` is high joins no group, and the counter returns to slot 0. The first sample taken with `rst_in` low fills slot 0. If `rst_in` is high at the edge that would close a group, the reset wins and the ports do not update.
- R8: After edge e, `rst_out` equals the value of `rst_in` sampled at edge e-LAT+1. Before enough edges have passed, it reads 1.
- R9: `dready` is held low whenever `rst_out` is high.
- R10: While `rst_n` is low, `pri_out` and `aux_out` are zero, `dready` is low and `rst_out` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, rising edge active |
| rst_n | input | 1 | Asynchronous block reset, active low |
| rst_in | input | 1 | Synchronous alignment reset, active high |
| demux_en | input | 1 | Divided-mode enable |
| div_sel | input | 1 | Divide select: 0 half rate, 1 quarter rate |
| smp_in | input | 8 | Input sample |
| pri_out | output | 16 | Primary port (newer samples of a group) |
| aux_out | output | 16 | Auxiliary port (older samples of a group) |
| dready | output | 1 | Data-ready strobe at the divided rate |
| rst_out | output | 1 | Alignment reset delayed to match the data path |

## Verification
The alignment reset and the closing of a group can land on the same clock edge. The bench forces this collision by watching its own model of the slot counter. When the model shows the next sample would complete a group, the bench raises `rst_in` at that edge. The check is that no port update follows from that incomplete group. A second check follows the delayed reset as it reaches the output stage while the quarter-rate `dready` pulse from the previous group is still high. There, `rst_out` must cut the pulse short, and the next group must restart at slot 0.

// File: rtl/sdmx_pkg.sv
package sdmx_pkg;

   typedef enum logic [1:0] {
      MODE_DIV1 = 2'd0,
      MODE_DIV2 = 2'd1,
      MODE_DIV4 = 2'd2
   } sdmx_mode_e;

   function automatic sdmx_mode_e mode_decode(input logic en, input logic sel);
      if (!en) begin
         return MODE_DIV1;
      end else if (!sel) begin
         return MODE_DIV2;
      end
      return MODE_DIV4;
   endfunction

   function automatic logic [1:0] last_slot(input sdmx_mode_e m);
      case (m)
         MODE_DIV2: return 2'd1;
         MODE_DIV4: return 2'd3;
         default:   return 2'd0;
      endcase
   endfunction

endpackage

// File: rtl/sdmx_phase_ctr.sv
module sdmx_phase_ctr
   import sdmx_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rst_in,
   input  sdmx_mode_e mode,
   output logic [1:0] slot
);

   logic [1:0] cnt_q;
   logic [1:0] cnt_d;
   logic [1:0] lim;

   assign lim = last_slot(mode);

   always_comb begin
      if (rst_in || cnt_q >= lim) begin
         cnt_d = 2'd0;
      end else begin
         cnt_d = cnt_q + 2'd1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= 2'd0;
      end else begin
         cnt_q <= cnt_d;
      end
   end

   assign slot = cnt_q;

   // R7: the alignment reset parks the counter at slot zero
   assert_cnt_cleared_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rst_in |=> (slot == 2'd0));

   // R7: a finished group is followed by slot zero
   assert_cnt_wraps_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!rst_in && slot == last_slot(mode)) |=> (slot == 2'd0));

endmodule

// File: rtl/sdmx_delay.sv
module sdmx_delay #(
   parameter int                WIDTH   = 8,
   parameter int                DEPTH   = 1,
   parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);

   if (WIDTH < 1) begin : g_bad_width
      $error("sdmx_delay: WIDTH must be positive");
   end
   if (DEPTH < 0) begin : g_bad_depth
      $error("sdmx_delay: DEPTH must not be negative");
   end

   if (DEPTH == 0) begin : g_pass
      assign dout = din;
   end else begin : g_regs
      logic [WIDTH-1:0] stg_q [DEPTH];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
               stg_q[i] <= RST_VAL;
            end
         end else begin
            stg_q[0] <= din;
            for (int i = 1; i < DEPTH; i++) begin
               stg_q[i] <= stg_q[i-1];
            end
         end
      end

      assign dout = stg_q[DEPTH-1];
   end

endmodule

// File: rtl/sdmx_pack.sv
module sdmx_pack
   import sdmx_pkg::*;
#(
   parameter int SMP_W = 8,
   localparam int VEC_W = SMP_W + 3,
   localparam int PORT_W = 2 * SMP_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  sdmx_mode_e        mode,
   input  logic [VEC_W-1:0]  tag_vec,
   output logic [PORT_W-1:0] pri_out,
   output logic [PORT_W-1:0] aux_out,
   output logic              dready,
   output logic              rst_out
);

   logic             tag_rst;
   logic [1:0]       tag_slot;
   logic [SMP_W-1:0] tag_dat;
   logic [SMP_W-1:0] h1_q, h2_q, h3_q;
   logic             load;
   logic             dr_next;
   logic [PORT_W-1:0] pri_d, aux_d;

   assign tag_rst  = tag_vec[VEC_W-1];
   assign tag_slot = tag_vec[SMP_W+1:SMP_W];
   assign tag_dat  = tag_vec[SMP_W-1:0];

   assign load = !tag_rst && (tag_slot == last_slot(mode));

   always_comb begin
      case (mode)
         MODE_DIV2: begin
            aux_d   = {{SMP_W{1'b0}}, h1_q};
            pri_d   = {{SMP_W{1'b0}}, tag_dat};
            dr_next = (tag_slot == 2'd1);
         end
         MODE_DIV4: begin
            aux_d   = {h2_q, h3_q};
            pri_d   = {tag_dat, h1_q};
            dr_next = (tag_slot == 2'd3) || (tag_slot == 2'd0 && dready);
         end
         default: begin
            aux_d   = '0;
            pri_d   = {{SMP_W{1'b0}}, tag_dat};
            dr_next = 1'b1;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         h1_q    <= '0;
         h2_q    <= '0;
         h3_q    <= '0;
         pri_out <= '0;
         aux_out <= '0;
         dready  <= 1'b0;
         rst_out <= 1'b1;
      end else begin
         h1_q    <= tag_dat;
         h2_q    <= h1_q;
         h3_q    <= h2_q;
         rst_out <= tag_rst;
         dready  <= !tag_rst && dr_next;
         if (load) begin
            pri_out <= pri_d;
            aux_out <= aux_d;
         end
      end
   end

   // R9: no data-ready while the delayed reset is visible
   assert_dready_low_in_rst_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rst_out |-> !dready);

   // R5: half-rate strobe lasts one cycle
   assert_div2_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_DIV2 && dready) |=> !dready);

   // R5: quarter-rate strobe lasts two cycles unless reset cuts it
   assert_div4_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_DIV4 && $rose(dready)) |=> (dready || rst_out));

   // R6: ports hold between strobes in divided modes
   assert_ports_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode != MODE_DIV1 && !$rose(dready)) |-> ($stable(pri_out) && $stable(aux_out)));

endmodule

// File: rtl/sample_demux_aligned.sv
module sample_demux_aligned
   import sdmx_pkg::*;
#(
   parameter int SMP_W = 8,
   parameter int LAT   = 3,
   localparam int VEC_W  = SMP_W + 3,
   localparam int PORT_W = 2 * SMP_W,
   localparam int MID_DEPTH = LAT - 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rst_in,
   input  logic              demux_en,
   input  logic              div_sel,
   input  logic [SMP_W-1:0]  smp_in,
   output logic [PORT_W-1:0] pri_out,
   output logic [PORT_W-1:0] aux_out,
   output logic              dready,
   output logic              rst_out
);

   localparam logic [VEC_W-1:0] PIPE_RST = {1'b1, {(VEC_W-1){1'b0}}};

   if (LAT < 2) begin : g_bad_lat
      $error("sample_demux_aligned: LAT must be at least 2");
   end
   if (SMP_W < 1) begin : g_bad_w
      $error("sample_demux_aligned: SMP_W must be positive");
   end

   sdmx_mode_e       mode;
   logic [1:0]       slot;
   logic [VEC_W-1:0] cap_q;
   logic [VEC_W-1:0] mid_vec;

   assign mode = mode_decode(demux_en, div_sel);

   sdmx_phase_ctr u_phase (
      .clk    (clk),
      .rst_n  (rst_n),
      .rst_in (rst_in),
      .mode   (mode),
      .slot   (slot)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_q <= PIPE_RST;
      end else begin
         cap_q <= {rst_in, slot, smp_in};
      end
   end

   sdmx_delay #(
      .WIDTH   (VEC_W),
      .DEPTH   (MID_DEPTH),
      .RST_VAL (PIPE_RST)
   ) u_mid (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (cap_q),
      .dout  (mid_vec)
   );

   sdmx_pack #(
      .SMP_W (SMP_W)
   ) u_pack (
      .clk     (clk),
      .rst_n   (rst_n),
      .mode    (mode),
      .tag_vec (mid_vec),
      .pri_out (pri_out),
      .aux_out (aux_out),
      .dready  (dready),
      .rst_out (rst_out)
   );

endmodule

// File: tb/sample_demux_aligned_tb_top.sv
module sample_demux_aligned_tb_top;

   localparam int LAT = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rst_in = 1'b1;
   logic        demux_en = 1'b0;
   logic        div_sel = 1'b0;
   logic [7:0]  smp_in = 8'h00;
   logic [15:0] pri_out, aux_out;
   logic        dready, rst_out;

   sample_demux_aligned #(.SMP_W(8), .LAT(LAT)) dut_i (
      .clk(clk), .rst_n(rst_n), .rst_in(rst_in), .demux_en(demux_en),
      .div_sel(div_sel), .smp_in(smp_in), .pri_out(pri_out),
      .aux_out(aux_out), .dready(dready), .rst_out(rst_out)
   );

   always #10 clk = ~clk;

   typedef struct {
      int          due;
      logic [15:0] p;
      logic [15:0] a;
   } exp_t;

   exp_t        q[$];
   logic [7:0]  grp[$];
   bit          rst_hist [0:8191];
   int          edge_n = 0;
   int          mcnt = 0;
   int          glen = 1;
   int          hi_left = 0;
   int          n_chk = 0;
   int          n_bad = 0;
   bit          mon_on = 1'b0;
   bit          done = 1'b0;
   logic [15:0] prev_p = '0, prev_a = '0;

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] expv);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s edge %0d: actual %h expected %h", req, edge_n, act, expv);
      end
   endtask

   task automatic finish_up();
      if (!done) begin
         done = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   task automatic set_mode(input logic en, input logic sel);
      demux_en = en;
      div_sel  = sel;
      glen = !en ? 1 : (!sel ? 2 : 4);
   endtask

   // driver: applies one sample, models the expected group result
   task automatic step(input logic [7:0] s, input logic r);
      exp_t e;
      smp_in = s;
      rst_in = r;
      @(posedge clk);
      edge_n++;
      rst_hist[edge_n] = r;
      if (r) begin
         mcnt = 0;
         grp.delete();
      end else begin
         if (mcnt == 0) grp.delete();
         grp.push_back(s);
         if (mcnt == glen - 1) begin
            e.due = edge_n + LAT - 1;
            case (glen)
               2: begin e.a = {8'h00, grp[0]}; e.p = {8'h00, grp[1]}; end
               4: begin e.a = {grp[1], grp[0]}; e.p = {grp[3], grp[2]}; end
               default: begin e.a = 16'h0000; e.p = {8'h00, grp[0]}; end
            endcase
            q.push_back(e);
         end
         mcnt = (mcnt + 1) % glen;
      end
      @(negedge clk);
   endtask

   // monitor: compares outputs after every edge
   always @(negedge clk) begin
      if (mon_on && !done) begin
         int  idx;
         bit  exp_r;
         bit  loaded;
         idx   = edge_n - LAT + 1;
         exp_r = (idx < 1) ? 1'b1 : rst_hist[idx];
         check(rst_out == exp_r, "R8 rst_out", 32'(rst_out), 32'(exp_r));
         if (exp_r) hi_left = 0;
         loaded = 1'b0;
         while (q.size() > 0 && q[0].due < edge_n) begin
            check(1'b0, "R2 missed update", 32'(edge_n), 32'(q[0].due));
            void'(q.pop_front());
         end
         if (q.size() > 0 && q[0].due == edge_n) begin
            loaded = 1'b1;
            // R1 R3 R4: port layout per mode
            check(pri_out == q[0].p, glen == 4 ? "R4 pri" : (glen == 2 ? "R3 pri" : "R1 pri"),
                  32'(pri_out), 32'(q[0].p));
            check(aux_out == q[0].a, glen == 4 ? "R4 aux" : (glen == 2 ? "R3 aux" : "R1 aux"),
                  32'(aux_out), 32'(q[0].a));
            hi_left = (glen == 1) ? 1 : glen / 2;
            void'(q.pop_front());
         end
         if (!loaded) begin
            check(pri_out == prev_p && aux_out == prev_a, "R6 R7 ports held",
                  {pri_out, aux_out}, {prev_p, prev_a});
         end
         check(dready == (hi_left > 0), exp_r ? "R9 dready in reset" : "R5 dready",
               32'(dready), 32'(hi_left > 0));
         if (hi_left > 0) hi_left--;
         prev_p = pri_out;
         prev_a = aux_out;
      end
   end

   initial begin
      #(20 * 200000);
      check(1'b0, "watchdog", 32'(edge_n), 32'd0);
      finish_up();
   end

   initial begin
      for (int i = 0; i < 8192; i++) rst_hist[i] = 1'b1;
      #55;
      // R10: block reset state
      check(pri_out == 16'h0 && aux_out == 16'h0, "R10 ports", {pri_out, aux_out}, 32'd0);
      check(dready == 1'b0, "R10 dready", 32'(dready), 32'd0);
      check(rst_out == 1'b1, "R10 rst_out", 32'(rst_out), 32'd1);
      @(negedge clk);
      rst_n  = 1'b1;
      mon_on = 1'b1;

      for (int m = 0; m < 5; m++) begin
         repeat (3) step(8'($urandom_range(0, 255)), 1'b1);
         case (m)
            0: set_mode(1'b0, 1'b0);
            1: set_mode(1'b1, 1'b0);
            2: set_mode(1'b1, 1'b1);
            3: set_mode(1'b1, 1'b0);
            default: set_mode(1'b1, 1'b1);
         endcase
         repeat (4) step(8'($urandom_range(0, 255)), 1'b1);
         repeat (30) step(8'($urandom_range(0, 255)), 1'b0);
         // R7: reset lands on the edge that would close a group
         while (mcnt != glen - 1) step(8'($urandom_range(0, 255)), 1'b0);
         step(8'hA5, 1'b1);
         if (m == 4) begin
            // short reset: delayed reset meets a live quarter-rate pulse
            repeat (20) step(8'($urandom_range(0, 255)), 1'b0);
            while (mcnt != 0) step(8'($urandom_range(0, 255)), 1'b0);
            step(8'h3C, 1'b1);
         end
         step(8'h5A, 1'b1);
         repeat (24) step(8'($urandom_range(0, 255)), 1'b0);
      end

      repeat (6) step(8'h00, 1'b1);
      check(q.size() == 0, "R2 all groups seen", 32'(q.size()), 32'd0);
      finish_up();
   end

endmodule